// File: doc/BRIEF.md
# Oversampled Serial Receiver with Flag Register Interface

This block is the receive half of an asynchronous serial port. A free-running oversample tick, sixteen ticks per bit by default, drives a bit sampler that resynchronises the incoming line and takes a majority vote of three samples around the middle of each bit. A framing engine strips the start bit and collects 8 or 9 data bits, least significant first. It can check a parity bit and then one or two stop bits. Each completed word moves into a one-deep holding register that software reads.

Besides the word itself, the holding stage reports a data-available flag, the received ninth bit and four error flags: noise, framing, parity and overrun. An interrupt request follows the data-available flag when the receive interrupt is enabled. Software acknowledges a word by pulsing a status-read strobe while data is available and then a data-read strobe. That pair empties the holding register and clears the error flags. Dropping the global enable returns the whole path to idle and drops any word still held.

Top module: `uart_rx_flags`

## Requirements
- R1: After reset, rx_avail, err_noise, err_frame, err_parity, err_overrun and irq are all 0.
- R2: A frame is a low start bit, the data bits least significant first, an optional parity bit and then the stop bits. The word appears on rx_data and rx_avail goes to 1 within two clock cycles after the middle of the last stop bit.
- R3: With cfg_nine=1 the frame carries 9 data bits and the ninth one (bit index 8) is shown on rx_bit8. With cfg_nine=0 rx_bit8 reads 0.
- R4: With cfg_par_en=1, one parity bit follows the data bits. cfg_par_odd=0 expects an even count of ones over data plus parity, and cfg_par_odd=1 expects an odd count. A mismatch sets err_parity together with rx_avail. With cfg_par_en=0 err_parity stays 0.
- R5: err_frame is set with the word when the first stop bit is sampled low. With cfg_two_stop=1 the level of the second stop bit does not affect err_frame.
- R6: Each bit is sampled at tick indices OVS/2-1, OVS/2 and OVS/2+1 within the bit, counting the tick that detected the start as index 0. The bit value is the majority of the three samples. err_noise is set with the word if the three samples of any bit of the frame (start, data, parity or stop) disagree.
- R7: A start bit whose mid-bit majority is high is discarded as a false start, and no word is produced.
- R8: A status-read strobe while rx_avail=1, followed later by a data-read strobe, clears rx_avail and all four error flags. A data-read strobe without that earlier status read changes nothing.
- R9: A word that completes while rx_avail=1 and the clearing pair has not finished is dropped. err_overrun is set, and rx_data and the other flags keep their values.
- R10: irq equals rie AND rx_avail.
- R11: While en=0 the receiver stays idle, and one cycle after en falls rx_avail and all error flags are 0. A frame cut by en=0 produces no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global enable; 0 holds the path idle and empties it |
| baud_tick | input | 1 | One-cycle pulse at OVS times the bit rate |
| rx | input | 1 | Serial receive line, idle high |
| cfg_nine | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | 1 enables the parity bit |
| cfg_par_odd | input | 1 | 0 even parity, 1 odd parity |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| rie | input | 1 | Receive interrupt enable |
| stat_rd | input | 1 | Status-read strobe |
| data_rd | input | 1 | Data-read strobe |
| rx_avail | output | 1 | Holding register holds an unread word |
| rx_data | output | DATA_W | Received data bits 0 to DATA_W-1 |
| rx_bit8 | output | 1 | Received ninth data bit |
| err_noise | output | 1 | Sample disagreement in the held word |
| err_frame | output | 1 | First stop bit sampled low |
| err_parity | output | 1 | Parity mismatch |
| err_overrun | output | 1 | A word was lost while the register was full |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench uses the default parameters: OVS=16, a two-stage line synchronizer and DATA_W=8, so the 9-bit path is reached through cfg_nine. The oversample tick pulses once every four clocks and the line changes three clocks before each tick. The synchronizer lag therefore stays inside one oversample slot, and a one-slot glitch at index OVS/2 lands on exactly one of the three votes. This makes noise, false-start and stop-bit cases repeatable at the exact vote positions. Randomly chosen frame formats, data and injected faults, with acknowledges sometimes skipped, also bring overruns within reach.

// File: rtl/uarx_pkg.sv
package uarx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP1,
      ST_STOP2
   } rx_state_e;

   typedef struct packed {
      logic noise;
      logic frame;
      logic parity;
   } word_err_t;

endpackage

// File: rtl/uarx_sampler.sv
module uarx_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic tick,
   input  logic rx,
   output logic rx_s,
   output logic maj,
   output logic dis
);

   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must not be negative");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign rx_s = rx;
   end else begin : g_sync
      for (genvar k = 0; k < SYNC_STAGES; k++) begin : g_st
         logic q;
         if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q <= 1'b1;
               else        q <= rx;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q <= 1'b1;
               else        q <= g_st[k-1].q;
            end
         end
      end
      assign rx_s = g_st[SYNC_STAGES-1].q;
   end

   // previous two tick samples; the current one is rx_s itself
   logic [1:0] hist;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hist <= 2'b11;
      else if (!en)    hist <= 2'b11;
      else if (tick)   hist <= {hist[0], rx_s};
   end

   assign maj = (hist[1] & hist[0]) | (hist[1] & rx_s) | (hist[0] & rx_s);
   assign dis = !((hist[1] == hist[0]) && (hist[0] == rx_s));

endmodule

// File: rtl/uarx_deframer.sv
module uarx_deframer
   import uarx_pkg::*;
#(
   parameter int OVS    = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  logic              rx_s,
   input  logic              maj,
   input  logic              dis,
   input  logic              cfg_nine,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_two_stop,
   output logic              word_vld,
   output logic [DATA_W:0]   word,
   output word_err_t         werr
);

   localparam int SH_W  = DATA_W + 1;
   localparam int CNT_W = $clog2(OVS);
   localparam int BN_W  = $clog2(SH_W + 1);
   localparam int MID   = OVS / 2;

   if (OVS < 4) begin : g_bad_ovs
      $error("OVS must be at least 4");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("DATA_W must be at least 1");
   end

   rx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [BN_W-1:0]   bitn;
   logic [SH_W-1:0]   sh;
   logic              par_bit;
   logic              noise_acc;
   logic              ferr_q;

   logic              decide;
   logic              bit_end;
   logic              last;
   logic [BN_W-1:0]   nbits;
   logic [SH_W-1:0]   asm_word;
   logic              emit_frame;
   logic              emit_par;

   assign decide   = tick && (state != ST_IDLE) && (cnt == CNT_W'(MID + 1));
   assign bit_end  = tick && (cnt == CNT_W'(OVS - 1));
   assign last     = ((state == ST_STOP1) && !cfg_two_stop) || (state == ST_STOP2);
   assign nbits    = cfg_nine ? BN_W'(SH_W) : BN_W'(DATA_W);
   assign asm_word = cfg_nine ? sh : {1'b0, sh[SH_W-1:1]};
   assign emit_frame = (state == ST_STOP1) ? !maj : ferr_q;
   assign emit_par   = cfg_par_en && (((^asm_word) ^ par_bit) != cfg_par_odd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;  cnt <= '0;  bitn <= '0;  sh <= '0;
         par_bit <= 1'b0;  noise_acc <= 1'b0;  ferr_q <= 1'b0;
         word_vld <= 1'b0;  word <= '0;  werr <= '0;
      end else if (!en) begin
         state <= ST_IDLE;  cnt <= '0;  bitn <= '0;
         noise_acc <= 1'b0;  ferr_q <= 1'b0;  word_vld <= 1'b0;
      end else begin
         word_vld <= 1'b0;
         if (state == ST_IDLE) begin
            if (tick && !rx_s) begin
               state <= ST_START;  cnt <= CNT_W'(1);  bitn <= '0;
               noise_acc <= 1'b0;  ferr_q <= 1'b0;
            end
         end else begin
            if (tick) cnt <= (cnt == CNT_W'(OVS - 1)) ? '0 : cnt + 1'b1;
            if (decide) noise_acc <= noise_acc | dis;
            case (state)
               ST_START: begin
                  if (decide && maj) state <= ST_IDLE;
                  else if (bit_end)  state <= ST_DATA;
               end
               ST_DATA: begin
                  if (decide) begin
                     sh   <= {maj, sh[SH_W-1:1]};
                     bitn <= bitn + 1'b1;
                  end
                  if (bit_end && bitn == nbits)
                     state <= cfg_par_en ? ST_PAR : ST_STOP1;
               end
               ST_PAR: begin
                  if (decide)  par_bit <= maj;
                  if (bit_end) state <= ST_STOP1;
               end
               ST_STOP1: begin
                  if (decide) ferr_q <= !maj;
                  if (bit_end) state <= ST_STOP2;
               end
               default: ;
            endcase
            if (decide && last) begin
               state       <= ST_IDLE;
               word_vld    <= 1'b1;
               word        <= asm_word;
               werr.noise  <= noise_acc | dis;
               werr.frame  <= emit_frame;
               werr.parity <= emit_par;
            end
         end
      end
   end

   a_r2_emit_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |-> ($past(state) == ST_STOP1 || $past(state) == ST_STOP2));

   a_r11_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (state == ST_IDLE && !word_vld));

   a_r7_one_word_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |=> !word_vld);

endmodule

// File: rtl/uarx_holding.sv
module uarx_holding
   import uarx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              word_vld,
   input  logic [DATA_W:0]   word,
   input  word_err_t         werr,
   input  logic              stat_rd,
   input  logic              data_rd,
   output logic              avail,
   output logic [DATA_W-1:0] data,
   output logic              bit8,
   output logic              nf,
   output logic              ff,
   output logic              pf,
   output logic              of
);

   logic armed;
   logic clr;

   assign clr = data_rd && armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         avail <= 1'b0;  data <= '0;  bit8 <= 1'b0;  armed <= 1'b0;
         nf <= 1'b0;  ff <= 1'b0;  pf <= 1'b0;  of <= 1'b0;
      end else if (!en) begin
         avail <= 1'b0;  armed <= 1'b0;
         nf <= 1'b0;  ff <= 1'b0;  pf <= 1'b0;  of <= 1'b0;
      end else begin
         if (stat_rd && avail) armed <= 1'b1;
         if (clr) begin
            avail <= 1'b0;  armed <= 1'b0;
            nf <= 1'b0;  ff <= 1'b0;  pf <= 1'b0;  of <= 1'b0;
         end
         if (word_vld) begin
            if (avail && !clr) begin
               of <= 1'b1;
            end else begin
               avail <= 1'b1;
               data  <= word[DATA_W-1:0];
               bit8  <= word[DATA_W];
               nf    <= werr.noise;
               ff    <= werr.frame;
               pf    <= werr.parity;
            end
         end
      end
   end

   a_r2_avail_from_word: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(avail) |-> $past(word_vld));

   a_r8_avail_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(avail) |-> ($past(data_rd && armed) || !$past(en)));

   a_r9_overrun_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
      (en && word_vld && avail && !clr) |=> (of && avail && $stable(data)));

   a_r11_empty_after_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!avail && !of && !nf && !ff && !pf));

endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
   import uarx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              baud_tick,
   input  logic              rx,
   input  logic              cfg_nine,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_two_stop,
   input  logic              rie,
   input  logic              stat_rd,
   input  logic              data_rd,
   output logic              rx_avail,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_bit8,
   output logic              err_noise,
   output logic              err_frame,
   output logic              err_parity,
   output logic              err_overrun,
   output logic              irq
);

   logic              rx_s;
   logic              maj;
   logic              dis;
   logic              word_vld;
   logic [DATA_W:0]   word;
   word_err_t         werr;

   uarx_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk(clk), .rst_n(rst_n), .en(en), .tick(baud_tick), .rx(rx),
      .rx_s(rx_s), .maj(maj), .dis(dis)
   );

   uarx_deframer #(.OVS(OVS), .DATA_W(DATA_W)) u_deframer (
      .clk(clk), .rst_n(rst_n), .en(en), .tick(baud_tick),
      .rx_s(rx_s), .maj(maj), .dis(dis),
      .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en),
      .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
      .word_vld(word_vld), .word(word), .werr(werr)
   );

   uarx_holding #(.DATA_W(DATA_W)) u_holding (
      .clk(clk), .rst_n(rst_n), .en(en),
      .word_vld(word_vld), .word(word), .werr(werr),
      .stat_rd(stat_rd), .data_rd(data_rd),
      .avail(rx_avail), .data(rx_data), .bit8(rx_bit8),
      .nf(err_noise), .ff(err_frame), .pf(err_parity), .of(err_overrun)
   );

   assign irq = rie & rx_avail;

   a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (rie && rx_avail));

endmodule

// File: tb/uart_rx_flags_bench.sv
module uart_rx_flags_bench;

   localparam int CLK_PERIOD = 10;
   localparam int OVS        = 16;
   localparam int DW         = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, baud_tick = 1'b0, rx = 1'b1, rie = 1'b0;
   logic cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
   logic stat_rd = 1'b0, data_rd = 1'b0;
   logic rx_avail, rx_bit8, err_noise, err_frame, err_parity, err_overrun, irq;
   logic [DW-1:0] rx_data;

   int n_cmp = 0;
   int n_bad = 0;
   bit reported = 0;

   // bench model of the visible register state
   logic m_avail = 0, m_b8 = 0, m_nf = 0, m_ff = 0, m_pf = 0, m_of = 0;
   logic [DW-1:0] m_data = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_rx_flags u_uart_rx_flags (
      .clk(clk), .rst_n(rst_n), .en(en), .baud_tick(baud_tick), .rx(rx),
      .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .cfg_two_stop(cfg_two_stop), .rie(rie), .stat_rd(stat_rd), .data_rd(data_rd),
      .rx_avail(rx_avail), .rx_data(rx_data), .rx_bit8(rx_bit8),
      .err_noise(err_noise), .err_frame(err_frame), .err_parity(err_parity),
      .err_overrun(err_overrun), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   function automatic logic par_of(input logic [8:0] d, input logic nine, input logic odd);
      return (^(nine ? d : {1'b0, d[7:0]})) ^ odd;
   endfunction

   task automatic slot(input logic lvl);
      rx = lvl;
      baud_tick = 1'b0;
      repeat (3) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
   endtask

   task automatic send_bit(input logic lvl, input bit glitch);
      for (int s = 0; s < OVS; s++) slot((glitch && s == OVS/2) ? ~lvl : lvl);
   endtask

   task automatic idle(input int n);
      for (int s = 0; s < n; s++) slot(1'b1);
   endtask

   function automatic int frame_bits();
      return 2 + (cfg_nine ? 9 : 8) + (cfg_par_en ? 1 : 0) + (cfg_two_stop ? 1 : 0);
   endfunction

   task automatic send_frame(input logic [8:0] d, input bit bad_par, input bit bad_s1,
                             input bit bad_s2, input int nz);
      int idx;
      idx = 0;
      send_bit(1'b0, nz == idx); idx++;
      for (int b = 0; b < (cfg_nine ? 9 : 8); b++) begin
         send_bit(d[b], nz == idx); idx++;
      end
      if (cfg_par_en) begin
         send_bit(par_of(d, cfg_nine, cfg_par_odd) ^ bad_par, nz == idx); idx++;
      end
      send_bit(!bad_s1, nz == idx); idx++;
      if (cfg_two_stop) begin
         send_bit(!bad_s2, nz == idx); idx++;
      end
      idle(20);
      if (m_avail) m_of = 1'b1;
      else begin
         m_avail = 1'b1;
         m_data  = d[7:0];
         m_b8    = cfg_nine ? d[8] : 1'b0;
         m_nf    = (nz >= 0);
         m_ff    = bad_s1;
         m_pf    = cfg_par_en && bad_par;
      end
   endtask

   task automatic check_all(input string tag);
      chk({tag, " R2 avail"},   rx_avail, m_avail);
      if (m_avail) chk({tag, " R2 data"}, rx_data, m_data);
      if (m_avail) chk({tag, " R3 bit8"}, rx_bit8, m_b8);
      chk({tag, " R6 noise"},   err_noise, m_nf);
      chk({tag, " R5 frame"},   err_frame, m_ff);
      chk({tag, " R4 parity"},  err_parity, m_pf);
      chk({tag, " R9 overrun"}, err_overrun, m_of);
      chk({tag, " R10 irq"},    irq, rie & m_avail);
   endtask

   task automatic read_clear();
      stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
      data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
      if (m_avail) begin
         m_avail = 0; m_nf = 0; m_ff = 0; m_pf = 0; m_of = 0;
      end
   endtask

   task automatic set_cfg(input logic nine, input logic pen, input logic odd, input logic two);
      cfg_nine = nine; cfg_par_en = pen; cfg_par_odd = odd; cfg_two_stop = two;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 avail", rx_avail, 0);
      chk("R1 errors", {err_noise, err_frame, err_parity, err_overrun}, 0);
      chk("R1 irq", irq, 0);
      rst_n = 1'b1; @(negedge clk);
      chk("R1 after release", {rx_avail, err_overrun, irq}, 0);
      en = 1'b1; rie = 1'b1;
      idle(4);

      // R2 plain 8-bit frame
      set_cfg(0, 0, 0, 0);
      send_frame(9'h0A5, 0, 0, 0, -1); check_all("r2_plain");
      read_clear(); check_all("r8_clear");

      // R3 nine bits with even parity (R4)
      set_cfg(1, 1, 0, 0);
      send_frame(9'h1C3, 0, 0, 0, -1); check_all("r3_nine");
      read_clear();
      // R4 odd parity, wrong parity bit
      set_cfg(0, 1, 1, 0);
      send_frame(9'h03C, 1, 0, 0, -1); check_all("r4_bad_odd");
      read_clear();
      set_cfg(1, 1, 1, 1);
      send_frame(9'h100, 1, 0, 0, -1); check_all("r4_bad_nine");
      read_clear();

      // R5 low first stop, and low second stop ignored
      set_cfg(0, 0, 0, 0);
      send_frame(9'h055, 0, 1, 0, -1); check_all("r5_stop1");
      read_clear();
      set_cfg(0, 0, 0, 1);
      send_frame(9'h0AA, 0, 0, 1, -1); check_all("r5_stop2");
      read_clear();

      // R6 glitch on a data bit and on the start bit
      set_cfg(0, 0, 0, 0);
      send_frame(9'h0F0, 0, 0, 0, 4); check_all("r6_data");
      read_clear();
      send_frame(9'h00F, 0, 0, 0, 0); check_all("r6_start");
      read_clear();

      // R7 false start: short low pulse
      for (int s = 0; s < 4; s++) slot(1'b0);
      idle(40);
      chk("R7 no word", rx_avail, 0);
      send_frame(9'h081, 0, 0, 0, -1); check_all("r7_after");

      // R8 data read without status read keeps the word
      data_rd = 1'b1; @(negedge clk); data_rd = 1'b0; @(negedge clk);
      check_all("r8_data_only");
      read_clear(); check_all("r8_pair");

      // R9 overrun
      send_frame(9'h011, 0, 0, 0, -1);
      send_frame(9'h0EE, 0, 1, 0, 2);
      check_all("r9_overrun");
      read_clear(); check_all("r9_cleared");

      // R10 irq gate
      send_frame(9'h033, 0, 0, 0, -1);
      rie = 1'b0; @(negedge clk); check_all("r10_off");
      rie = 1'b1; @(negedge clk); check_all("r10_on");

      // R11 disable drops word and flags
      send_frame(9'h044, 0, 0, 0, -1);
      en = 1'b0; @(negedge clk); @(negedge clk);
      m_avail = 0; m_nf = 0; m_ff = 0; m_pf = 0; m_of = 0;
      check_all("r11_off");
      en = 1'b1;
      send_bit(1'b0, 0); send_bit(1'b1, 0); send_bit(1'b0, 0);
      en = 1'b0; @(negedge clk); en = 1'b1;
      idle(OVS * 12);
      chk("R11 cut frame", rx_avail, 0);

      // random frames
      for (int it = 0; it < 40; it++) begin
         logic [8:0] d;
         bit bp, bs1, bs2;
         int nz;
         set_cfg($urandom_range(1), $urandom_range(1), $urandom_range(1), $urandom_range(1));
         d   = 9'($urandom);
         bp  = cfg_par_en && ($urandom_range(3) == 0);
         bs1 = ($urandom_range(4) == 0);
         bs2 = ($urandom_range(3) == 0);
         nz  = ($urandom_range(2) == 0) ? $urandom_range(frame_bits() - 1) : -1;
         rie = $urandom_range(1);
         send_frame(d, bp, bs1, bs2, nz);
         check_all("rand");
         if ($urandom_range(3) != 0) begin
            read_clear();
            check_all("rand_clear");
         end
      end

      report();
   end

endmodule